// File: doc/BRIEF.md
# DRAM Periodic Refresh Scheduler

This block keeps DRAM contents alive by spreading refreshes evenly across the retention period. At build time it divides the retention time by the number of rows. The result, counted in clock cycles, is the per-row refresh interval. A free-running timebase marks the end of each interval. Every such mark leaves one refresh owed. While a refresh is owed and none is running, the block raises a request toward the command arbiter and asserts a stall that holds off normal traffic.

When the arbiter grants, the block opens a busy window. The window lasts one row cycle plus two cycles of margin. Stall stays high for the whole window. When the window closes, the block moves to the next row and wraps back to row 0 after the last row. The row address output always names the row that the next or current refresh applies to.

The timebase never waits for the arbiter, so a late grant does not shift later refreshes. If several interval marks pass before the arbiter grants, the block serves the backlog one refresh per grant.

Top module: `refresh_scheduler`

## Requirements
- R1: The interval is INTERVAL = floor(RETENTION_US × CLK_MHZ / NUM_ROWS) cycles, rounded down so it never exceeds retention divided by rows. `ref_req` first goes high exactly INTERVAL rising edges after reset is released.
- R2: While `rst` is high, and right after it falls, `ref_req`, `ref_active` and `stall` are 0 and `ref_row` is 0.
- R3: Once high, `ref_req` stays high until a cycle with `ref_gnt` = 1. `stall` is 1 whenever `ref_req` is 1.
- R4: A clock edge with `ref_req` = 1 and `ref_gnt` = 1 starts a refresh. From that edge, `ref_active` and `stall` stay 1 for exactly T_RC_CYC + 2 cycles, and `ref_req` stays 0 during that time.
- R5: `ref_row` changes only when a refresh window ends. It then steps by one, from NUM_ROWS−1 back to 0.
- R6: Requests from the timebase arrive on a fixed grid of multiples of INTERVAL edges after reset, however late earlier grants were.
- R7: `ref_gnt` = 1 while `ref_req` = 0 has no effect. This holds both when idle and during a refresh window: no new window starts, the window length does not change, and the row does not change.
- R8: Interval marks that pass before a grant are each kept, up to OWED_MAX. When a window ends with refreshes still owed, `ref_req` is 1 in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the refresh timebase |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Arbiter grant for the pending refresh |
| ref_req | output | 1 | Refresh request to the arbiter |
| ref_active | output | 1 | Refresh window in progress |
| stall | output | 1 | Hold off normal traffic |
| ref_row | output | ROW_W | Row address of the current or next refresh |

## Verification
The assertions assume that the arbiter may hold `ref_gnt` high at any time, including while no request is pending. The row and window checks assume the configured interval is longer than a refresh window. The stimulus drives the grant only between clock edges, as single-cycle pulses. Some of these pulses are aimed on purpose at idle and busy periods. The chosen configuration gives an interval of 1000 cycles against a 12-cycle window, and the backlog never exceeds two owed refreshes.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } ref_state_e;

    typedef struct packed {
        logic tick;   // interval boundary reached
        logic take;   // grant accepted
        logic done;   // refresh window closing
    } ref_evt_t;

    // Retention time split evenly over the rows; rounded down so the
    // spacing never grows beyond what retention allows.
    function automatic int unsigned interval_cycles(
        input int unsigned ret_us,
        input int unsigned mhz,
        input int unsigned rows
    );
        longint unsigned prod;
        prod = longint'(ret_us) * longint'(mhz);
        return 32'(prod / longint'(rows));
    endfunction

    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/refsched_tick.sv
module refsched_tick
    import refsched_pkg::*;
#(
    parameter int unsigned INTERVAL = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = width_of(INTERVAL);

    logic [CW-1:0] cnt;

    assign tick = (cnt == '0);

    // Free-running: never paused by the arbiter, so the grid stays fixed.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CW'(INTERVAL - 1);
        end else if (tick) begin
            cnt <= CW'(INTERVAL - 1);
        end else begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/refsched_owed.sv
module refsched_owed
    import refsched_pkg::*;
#(
    parameter int unsigned OWED_MAX = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic take,
    output logic pending
);
    localparam int unsigned OW = width_of(OWED_MAX + 1);

    logic [OW-1:0] owed;

    assign pending = (owed != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            owed <= '0;
        end else if (tick && !take) begin
            if (owed != OW'(OWED_MAX)) begin
                owed <= owed + 1'b1;
            end
        end else if (take && !tick) begin
            owed <= owed - 1'b1;
        end
    end
endmodule

// File: rtl/refsched_ctrl.sv
module refsched_ctrl
    import refsched_pkg::*;
#(
    parameter int unsigned BUSY_LEN = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic pending,
    input  logic gnt,
    output logic req,
    output logic active,
    output logic take,
    output logic done
);
    localparam int unsigned BW = width_of(BUSY_LEN);

    ref_state_e    state;
    logic [BW-1:0] bcnt;

    assign req    = pending && (state == ST_IDLE);
    assign active = (state == ST_BUSY);
    assign take   = req && gnt;
    assign done   = active && (bcnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            bcnt  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (take) begin
                        state <= ST_BUSY;
                        bcnt  <= BW'(BUSY_LEN - 1);
                    end
                end
                ST_BUSY: begin
                    if (bcnt == '0) begin
                        state <= ST_IDLE;
                    end else begin
                        bcnt <= bcnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/refsched_row.sv
module refsched_row
    import refsched_pkg::*;
#(
    parameter int unsigned ROWS = 8192
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      step,
    output logic [width_of(ROWS)-1:0] row
);
    localparam int unsigned RW = width_of(ROWS);

    always_ff @(posedge clk) begin
        if (rst) begin
            row <= '0;
        end else if (step) begin
            row <= (row == RW'(ROWS - 1)) ? '0 : row + 1'b1;
        end
    end
endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
    import refsched_pkg::*;
#(
    parameter int unsigned CLK_MHZ      = 125,
    parameter int unsigned RETENTION_US = 64000,
    parameter int unsigned NUM_ROWS     = 8192,
    parameter int unsigned T_RC_CYC     = 48,
    parameter int unsigned MARGIN_CYC   = 2,
    parameter int unsigned OWED_MAX     = 8,
    localparam int unsigned ROW_W       = width_of(NUM_ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_gnt,
    output logic             ref_req,
    output logic             ref_active,
    output logic             stall,
    output logic [ROW_W-1:0] ref_row
);
    localparam int unsigned INTERVAL = interval_cycles(RETENTION_US, CLK_MHZ, NUM_ROWS);
    localparam int unsigned BUSY_LEN = T_RC_CYC + MARGIN_CYC;

    ref_evt_t evt;
    logic     pending;

    refsched_tick #(.INTERVAL(INTERVAL)) tick_i (
        .clk  (clk),
        .rst  (rst),
        .tick (evt.tick)
    );

    refsched_owed #(.OWED_MAX(OWED_MAX)) owed_i (
        .clk     (clk),
        .rst     (rst),
        .tick    (evt.tick),
        .take    (evt.take),
        .pending (pending)
    );

    refsched_ctrl #(.BUSY_LEN(BUSY_LEN)) ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .pending (pending),
        .gnt     (ref_gnt),
        .req     (ref_req),
        .active  (ref_active),
        .take    (evt.take),
        .done    (evt.done)
    );

    refsched_row #(.ROWS(NUM_ROWS)) row_i (
        .clk  (clk),
        .rst  (rst),
        .step (evt.done),
        .row  (ref_row)
    );

    assign stall = ref_req || ref_active;
endmodule

// File: rtl/refsched_chk.sv
module refsched_chk #(
    parameter int unsigned INTERVAL = 1000,
    parameter int unsigned BUSY_LEN = 12,
    parameter int unsigned ROWS     = 8192,
    parameter int unsigned ROW_W    = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             ref_gnt,
    input logic             ref_req,
    input logic             ref_active,
    input logic             stall,
    input logic [ROW_W-1:0] ref_row
);
    logic [31:0] grid;
    logic [31:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            grid <= '0;
            run  <= '0;
        end else begin
            grid <= (grid == INTERVAL - 1) ? '0 : grid + 1;
            run  <= ref_active ? run + 1 : '0;
        end
    end

    // R2
    a_r2_quiet_in_reset: assert property (@(posedge clk)
        rst |=> (!ref_req && !ref_active && ref_row == '0));

    a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
        ref_req && !ref_gnt |=> ref_req);

    a_r3_stall_on_req: assert property (@(posedge clk) disable iff (rst)
        ref_req |-> stall);

    a_r4_grant_opens: assert property (@(posedge clk) disable iff (rst)
        ref_req && ref_gnt |=> ref_active && stall && !ref_req);

    a_r4_no_req_busy: assert property (@(posedge clk) disable iff (rst)
        ref_active |-> !ref_req);

    a_r4_window_len: assert property (@(posedge clk) disable iff (rst)
        $fell(ref_active) |-> run == BUSY_LEN);

    a_r4_window_cap: assert property (@(posedge clk) disable iff (rst)
        ref_active |-> run < BUSY_LEN);

    a_r5_row_at_end: assert property (@(posedge clk) disable iff (rst)
        !$stable(ref_row) |-> ($past(ref_active) && !ref_active));

    a_r5_row_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(ref_row) |->
            (ref_row == (($past(ref_row) == ROW_W'(ROWS - 1)) ? '0 : $past(ref_row) + 1'b1)));

    a_r6_on_grid: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_req) && !$past(ref_active) |-> grid == 0);

    a_r7_idle_gnt: assert property (@(posedge clk) disable iff (rst)
        !ref_req && !ref_active && ref_gnt |=> !ref_active);
endmodule

bind refresh_scheduler refsched_chk #(
    .INTERVAL (INTERVAL),
    .BUSY_LEN (BUSY_LEN),
    .ROWS     (NUM_ROWS),
    .ROW_W    (ROW_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .ref_gnt    (ref_gnt),
    .ref_req    (ref_req),
    .ref_active (ref_active),
    .stall      (stall),
    .ref_row    (ref_row)
);

// File: tb/refresh_scheduler_tb.sv
`timescale 1ns/1ps
module refresh_scheduler_tb_top;
    localparam int IV   = 1000;   // 64 us * 125 MHz / 8 rows
    localparam int BL   = 12;     // 10 + 2
    localparam int NR   = 8;
    localparam int RW   = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_gnt = 1'b0;
    logic          ref_req;
    logic          ref_active;
    logic          stall;
    logic [RW-1:0] ref_row;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    always @(posedge clk) if (!rst) cyc <= cyc + 1;

    refresh_scheduler #(
        .CLK_MHZ      (125),
        .RETENTION_US (64),
        .NUM_ROWS     (NR),
        .T_RC_CYC     (10),
        .MARGIN_CYC   (2),
        .OWED_MAX     (4)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .ref_gnt    (ref_gnt),
        .ref_req    (ref_req),
        .ref_active (ref_active),
        .stall      (stall),
        .ref_row    (ref_row)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic pulse_gnt;
        ref_gnt = 1'b1;
        @(negedge clk);
        ref_gnt = 1'b0;
    endtask

    // Grants a pending request and follows the whole window.
    task automatic run_refresh(input int exp_row, input string tag);
        int bad = 0;
        pulse_gnt();
        chk(ref_active && stall && !ref_req, {tag, " R4 window open"},
            {ref_active, stall, ref_req}, 3'b110);
        for (int k = 1; k < BL; k++) begin
            @(negedge clk);
            if (!ref_active || !stall || ref_req) bad++;
        end
        chk(bad == 0, {tag, " R4 window held"}, bad, 0);
        @(negedge clk);
        chk(!ref_active && ref_row == RW'(exp_row), {tag, " R5 window end row"},
            ref_row, exp_row);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(!ref_req && !ref_active && !stall && ref_row == 0, "R2 in reset",
            {ref_req, ref_active, stall}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!ref_req && !stall && ref_row == 0, "R2 after release", ref_row, 0);
    endtask

    task automatic t_first;
        wait_cyc(IV - 1);
        chk(!ref_req && !stall, "R1 no request before interval", ref_req, 0);
        wait_cyc(IV);
        chk(ref_req && stall, "R1 request at interval", ref_req, 1);
    endtask

    task automatic t_hold;
        wait_cyc(IV + 300);
        chk(ref_req && stall && ref_row == 0, "R3 request held", ref_req, 1);
        run_refresh(1, "first");
        chk(!stall && !ref_req, "R4 stall released", stall, 0);
    endtask

    task automatic t_drift_and_busy_gnt;
        wait_cyc(2 * IV - 1);
        chk(!ref_req, "R6 no early request", ref_req, 0);
        wait_cyc(2 * IV);
        chk(ref_req, "R6 request on grid after late grant", ref_req, 1);
        pulse_gnt();                 // accepted: window starts at cycle 2*IV+1
        @(negedge clk);
        pulse_gnt();                 // lands inside the window
        wait_cyc(2 * IV + BL);
        chk(ref_active && ref_row == 2'd1, "R7 busy grant keeps window", ref_active, 1);
        wait_cyc(2 * IV + BL + 1);
        chk(!ref_active && ref_row == 3'd2, "R7 busy grant single step", ref_row, 2);
    endtask

    task automatic t_idle_gnt;
        wait_cyc(2 * IV + 200);
        pulse_gnt();
        chk(!ref_active && !ref_req && !stall, "R7 idle grant ignored", ref_active, 0);
        @(negedge clk);
        chk(ref_row == 3'd2 && !ref_active, "R7 idle grant row kept", ref_row, 2);
    endtask

    task automatic t_backlog;
        wait_cyc(3 * IV);
        chk(ref_req, "R6 third request on grid", ref_req, 1);
        wait_cyc(4 * IV + 5);
        chk(ref_req && ref_row == 3'd2, "R8 backlog pending", ref_req, 1);
        run_refresh(3, "backlog1");
        chk(ref_req, "R8 second owed request follows", ref_req, 1);
        run_refresh(4, "backlog2");
        chk(!ref_req && !stall, "R8 backlog cleared", ref_req, 0);
        wait_cyc(5 * IV - 1);
        chk(!ref_req, "R6 grid kept after backlog", ref_req, 0);
    endtask

    task automatic t_wrap;
        for (int k = 5; k <= 8; k++) begin
            wait_cyc(k * IV);
            chk(ref_req, "R6 periodic request", ref_req, 1);
            run_refresh(k % NR, "wrap");
        end
        chk(ref_row == 0, "R5 row wraps to zero", ref_row, 0);
    endtask

    initial begin
        t_reset();
        t_first();
        t_hold();
        t_drift_and_busy_gnt();
        t_idle_gnt();
        t_backlog();
        t_wrap();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (30000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule